// File: doc/BRIEF.md
# AES Row Rotation and Column Mixing Unit

This block performs the two linear steps of an AES round on a 128-bit state in a single pass. When `enc_mode` is high it rotates the rows of the state and then mixes each column. When `enc_mode` is low it undoes the column mixing and then rotates the rows back. For decryption the unit therefore covers the span that runs from the round-key addition to the inverse byte substitution. Setting `skip_mix` leaves out the column stage in either direction, as the final round of the cipher requires. The result is registered, so it appears one cycle after the input.

All finite-field products come from one doubling primitive, which multiplies by x and reduces by 0x1B. There is no general multiplier. The forward and inverse column mixers share one network: the inverse result is the forward result XORed with a correction term that is built from the column sum and from the sums of byte pairs. Byte substitution, key addition, the key schedule and the sequencing of rounds are left to the logic around the unit.

Top module: `aes_rowmix_unit`

## Requirements
- R1: The state is column-major. The byte in row r, column c has index k = 4c + r and occupies bits 8k+7 down to 8k of both `in_state` and `out_state`.
- R2: With `enc_mode`=1 and `skip_mix`=0, the unit first rotates the rows as in R4. It then replaces each column (a0,a1,a2,a3) by out_r = 02·a_r ^ 03·a_(r+1) ^ a_(r+2) ^ a_(r+3), with row indices taken mod 4 and products taken in GF(2^8) modulo x^8+x^4+x^3+x+1.
- R3: With `enc_mode`=0 and `skip_mix`=0, the unit first replaces each column by out_r = 0E·a_r ^ 0B·a_(r+1) ^ 0D·a_(r+2) ^ 09·a_(r+3). It then applies the inverse rotation of R5.
- R4: With `enc_mode`=1 and `skip_mix`=1, the output byte at (r,c) equals the input byte at (r,(c+r) mod 4). Row r rotates left by r positions and no mixing takes place.
- R5: With `enc_mode`=0 and `skip_mix`=1, the output byte at (r,c) equals the input byte at (r,(c−r) mod 4). Row r rotates right by r positions and no mixing takes place.
- R6: An input accepted with `in_vld`=1 at a rising edge sets `out_vld` to 1 and gives its result on `out_state` right after that same edge.
- R7: At an edge with `in_vld`=0, `out_vld` goes to 0 and `out_state` keeps its previous value, whatever the other inputs are.
- R8: While `rst` is high at a rising edge, `out_vld` and `out_state` are cleared to 0.
- R9: A state whose sixteen bytes are all equal comes out unchanged in all four combinations of `enc_mode` and `skip_mix`.
- R10: Running a state in encrypt mode and then running the result in decrypt mode, with the same `skip_mix` value, gives back the original state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input state is valid this cycle |
| in_state | input | 128 | State to transform, column-major bytes |
| enc_mode | input | 1 | 1 selects the forward transforms, 0 the inverse |
| skip_mix | input | 1 | 1 skips the column stage (final round) |
| out_vld | output | 1 | Result on out_state is valid |
| out_state | output | 128 | Transformed state |

## Verification
The only state in the unit is the output register. Any fault in the datapath therefore shows up one cycle after the input that exposes it. A wrong rotation index moves a marked byte to the wrong position. A wrong coefficient term or a bad reduction constant corrupts the bytes of one column, and only for inputs whose top bits are set. For this reason random states are compared against a general shift-and-add field multiplier, and the known test column and round trips pin down the direction select. A stuck valid bit or a missing load enable shows up on the very next idle cycle as a change in `out_state` or a stray `out_vld`.

// File: rtl/aes_rowmix_pkg.sv
package aes_rowmix_pkg;

    localparam int BYTE_W  = 8;
    localparam int N_ROW   = 4;
    localparam int N_COL   = 4;
    localparam int N_BYTE  = N_ROW * N_COL;
    localparam int STATE_W = N_BYTE * BYTE_W;
    localparam int N_PAIR  = N_ROW / 2;

    // low byte of the reduction polynomial x^8+x^4+x^3+x+1
    localparam logic [BYTE_W-1:0] REDUCE_POLY = 8'h1B;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef byte_t [N_ROW-1:0] column_t;
    // grid[c][r] sits at bit offset BYTE_W*(N_ROW*c + r)
    typedef column_t [N_COL-1:0] grid_t;

    typedef enum logic {
        DIR_INV = 1'b0,
        DIR_FWD = 1'b1
    } dir_e;

    // per-column terms shared by all four output rows
    typedef struct packed {
        byte_t col_sum;
        byte_t sum_x8;
    } col_shared_t;

    // multiply by x in GF(2^8)
    function automatic byte_t xtime(input byte_t b);
        byte_t shifted;
        shifted = {b[BYTE_W-2:0], 1'b0};
        return b[BYTE_W-1] ? (shifted ^ REDUCE_POLY) : shifted;
    endfunction

    // multiply by x^2
    function automatic byte_t xtime2(input byte_t b);
        return xtime(xtime(b));
    endfunction

    // multiply by x^3
    function automatic byte_t xtime3(input byte_t b);
        return xtime(xtime2(b));
    endfunction

    // source column of a row rotation
    function automatic int src_col(input int row, input int col, input bit inverse);
        if (inverse)
            return (col + N_COL - row) % N_COL;
        return (col + row) % N_COL;
    endfunction

endpackage

// File: rtl/aes_row_rotate.sv
module aes_row_rotate
    import aes_rowmix_pkg::*;
#(
    parameter bit INVERSE = 1'b0
) (
    input  grid_t src,
    output grid_t dst
);
    // pure wiring: each output byte picks a fixed source column
    for (genvar c = 0; c < N_COL; c++) begin : g_col
        for (genvar r = 0; r < N_ROW; r++) begin : g_row
            localparam int SRC_C = src_col(r, c, INVERSE);
            assign dst[c][r] = src[SRC_C][r];
        end
    end

endmodule

// File: rtl/aes_col_mix.sv
module aes_col_mix
    import aes_rowmix_pkg::*;
(
    input  column_t col_in,
    input  dir_e    dir,
    output column_t col_out
);
    col_shared_t shared;
    byte_t       pair_x4 [N_PAIR];
    byte_t       fwd_row [N_ROW];
    byte_t       inv_fix [N_ROW];

    // sum of all four bytes, and that sum times x^3
    always_comb begin
        shared.col_sum = '0;
        for (int r = 0; r < N_ROW; r++)
            shared.col_sum = shared.col_sum ^ col_in[r];
        shared.sum_x8 = xtime3(shared.col_sum);
    end

    // rows r and r+2 share a x^2 term in the inverse
    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        assign pair_x4[p] = xtime2(col_in[p] ^ col_in[p + N_PAIR]);
    end

    for (genvar r = 0; r < N_ROW; r++) begin : g_out
        localparam int NXT = (r + 1) % N_ROW;
        // {02,03,01,01}: sum ^ a_r ^ x*(a_r ^ a_r+1)
        assign fwd_row[r] = shared.col_sum ^ col_in[r] ^ xtime(col_in[r] ^ col_in[NXT]);
        // {0E,0B,0D,09} minus the forward row: x^3*sum ^ x^2*(a_r ^ a_r+2)
        assign inv_fix[r] = shared.sum_x8 ^ pair_x4[r % N_PAIR];
        assign col_out[r] = (dir == DIR_INV) ? (fwd_row[r] ^ inv_fix[r]) : fwd_row[r];
    end

endmodule

// File: rtl/aes_rowmix_unit.sv
module aes_rowmix_unit
    import aes_rowmix_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_vld,
    input  logic [STATE_W-1:0] in_state,
    input  logic               enc_mode,
    input  logic               skip_mix,
    output logic               out_vld,
    output logic [STATE_W-1:0] out_state
);
    dir_e  dir;
    grid_t src_g;
    grid_t fwd_rot;
    grid_t mix_in;
    grid_t mix_out;
    grid_t body;
    grid_t inv_rot;
    grid_t result;

    assign dir   = dir_e'(enc_mode);
    assign src_g = grid_t'(in_state);

    // forward rotation ahead of the mixer (used when encrypting)
    aes_row_rotate #(.INVERSE(1'b0)) u_pre_rot (
        .src (src_g),
        .dst (fwd_rot)
    );

    assign mix_in = (dir == DIR_FWD) ? fwd_rot : src_g;

    // one shared mixer per column, serving both directions
    for (genvar c = 0; c < N_COL; c++) begin : g_mix
        aes_col_mix u_mix (
            .col_in  (mix_in[c]),
            .dir     (dir),
            .col_out (mix_out[c])
        );
    end

    assign body = skip_mix ? mix_in : mix_out;

    // inverse rotation behind the mixer (used when decrypting)
    aes_row_rotate #(.INVERSE(1'b1)) u_post_rot (
        .src (body),
        .dst (inv_rot)
    );

    assign result = (dir == DIR_FWD) ? body : inv_rot;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld   <= 1'b0;
            out_state <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld)
                out_state <= STATE_W'(result);
        end
    end

endmodule

// File: rtl/aes_rowmix_chk.sv
module aes_rowmix_chk
    import aes_rowmix_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_vld,
    input logic [STATE_W-1:0] in_state,
    input logic               enc_mode,
    input logic               skip_mix,
    input logic               out_vld,
    input logic [STATE_W-1:0] out_state
);
    logic in_uniform;
    assign in_uniform = (in_state == {N_BYTE{in_state[BYTE_W-1:0]}});

    // R6
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!out_vld && $stable(out_state)));

    // R8
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_vld && out_state == '0));

    // R4 R5: a bare rotation only permutes bits
    perm_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && skip_mix) |=> ($countones(out_state) == $countones($past(in_state))));

    // R9
    uniform_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_uniform) |=> (out_state == $past(in_state)));

    // R2 R3: mode inputs are never unknown while data is offered
    mode_known_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |-> !$isunknown({enc_mode, skip_mix}));

endmodule

bind aes_rowmix_unit aes_rowmix_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .in_state  (in_state),
    .enc_mode  (enc_mode),
    .skip_mix  (skip_mix),
    .out_vld   (out_vld),
    .out_state (out_state)
);

// File: tb/aes_rowmix_unit_tb.sv
module aes_rowmix_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 150;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_vld = 1'b0;
    logic [127:0] in_state = '0;
    logic         enc_mode = 1'b0;
    logic         skip_mix = 1'b0;
    logic         out_vld;
    logic [127:0] out_state;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aes_rowmix_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (in_vld),
        .in_state  (in_state),
        .enc_mode  (enc_mode),
        .skip_mix  (skip_mix),
        .out_vld   (out_vld),
        .out_state (out_state)
    );

    // general shift-and-add field multiply
    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = '0;
        logic [7:0] aa = a;
        logic [7:0] bb = b;
        for (int i = 0; i < 8; i++) begin
            if (bb[0]) p = p ^ aa;
            aa = aa[7] ? ({aa[6:0], 1'b0} ^ 8'h1B) : {aa[6:0], 1'b0};
            bb = bb >> 1;
        end
        return p;
    endfunction

    function automatic logic [7:0] coef(input int k, input bit inv);
        logic [7:0] f [4] = '{8'h02, 8'h03, 8'h01, 8'h01};
        logic [7:0] v [4] = '{8'h0E, 8'h0B, 8'h0D, 8'h09};
        return inv ? v[k] : f[k];
    endfunction

    function automatic logic [127:0] ref_rot(input logic [127:0] s, input bit inv);
        logic [127:0] o = '0;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) begin
                int sc = inv ? (c + 4 - r) % 4 : (c + r) % 4;
                o[8*(4*c+r) +: 8] = s[8*(4*sc+r) +: 8];
            end
        return o;
    endfunction

    function automatic logic [127:0] ref_mix(input logic [127:0] s, input bit inv);
        logic [127:0] o = '0;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) begin
                logic [7:0] acc = '0;
                for (int j = 0; j < 4; j++)
                    acc = acc ^ gmul(coef((j - r + 4) % 4, inv), s[8*(4*c+j) +: 8]);
                o[8*(4*c+r) +: 8] = acc;
            end
        return o;
    endfunction

    function automatic logic [127:0] model(input logic [127:0] s, input bit enc, input bit skip);
        if (enc)
            return skip ? ref_rot(s, 1'b0) : ref_mix(ref_rot(s, 1'b0), 1'b0);
        return skip ? ref_rot(s, 1'b1) : ref_rot(ref_mix(s, 1'b1), 1'b1);
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one vector at a falling edge; result is visible at the next falling edge
    task automatic push(input logic [127:0] s, input bit e, input bit k);
        @(negedge clk);
        in_vld   = 1'b1;
        in_state = s;
        enc_mode = e;
        skip_mix = k;
        @(negedge clk);
        in_vld   = 1'b0;
        in_state = ~s;
        enc_mode = ~e;
        skip_mix = ~k;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] x, y, held;
        void'($urandom(32'd20240517));

        // R8: reset clears outputs even with valid input offered
        in_vld   = 1'b1;
        in_state = rnd128();
        repeat (3) @(negedge clk);
        check("R8 out_vld", {127'd0, out_vld}, 128'd0);
        check("R8 out_state", out_state, 128'd0);
        rst    = 1'b0;
        in_vld = 1'b0;

        // R1 R4: byte at (row1,col0), index 1, lands at (row1,col3), index 13
        x = '0;
        x[8*1 +: 8] = 8'hA5;
        push(x, 1'b1, 1'b1);
        y = '0;
        y[8*13 +: 8] = 8'hA5;
        check("R1 R4 byte placement", out_state, y);
        check("R6 out_vld", {127'd0, out_vld}, 128'd1);

        // R5: byte at (row3,col1), index 7, lands at (row3,col0), index 3
        x = '0;
        x[8*7 +: 8] = 8'h3C;
        push(x, 1'b0, 1'b1);
        y = '0;
        y[8*3 +: 8] = 8'h3C;
        check("R5 byte placement", out_state, y);

        // R2: known column db,13,53,45 -> 8e,4d,a1,bc (rows constant across columns)
        push({4{32'h4553_13DB}}, 1'b1, 1'b0);
        check("R2 known column", out_state, {4{32'hBCA1_4D8E}});
        // R3: inverse of the same column
        push({4{32'hBCA1_4D8E}}, 1'b0, 1'b0);
        check("R3 known column", out_state, {4{32'h4553_13DB}});

        // R7: idle cycle with changed inputs holds the output
        held = out_state;
        @(negedge clk);
        check("R7 hold state", out_state, held);
        check("R7 out_vld low", {127'd0, out_vld}, 128'd0);

        // R9: uniform states in every mode
        for (int m = 0; m < 4; m++) begin
            x = {16{8'hC7 ^ 8'(m)}};
            push(x, m[0], m[1]);
            check("R9 uniform", out_state, x);
        end

        // R2 R3 R4 R5 R6: random states in every mode, plus all-ones corners
        for (int m = 0; m < 4; m++) begin
            push({128{1'b1}}, m[0], m[1]);
            check("R2-corner ones", out_state, model({128{1'b1}}, m[0], m[1]));
        end
        for (int i = 0; i < N_RAND; i++) begin
            bit e = 1'($urandom);
            bit k = 1'($urandom);
            x = rnd128();
            push(x, e, k);
            if (e && !k)       check("R2 random", out_state, model(x, e, k));
            else if (!e && !k) check("R3 random", out_state, model(x, e, k));
            else if (e)        check("R4 random", out_state, model(x, e, k));
            else               check("R5 random", out_state, model(x, e, k));
            check("R6 valid", {127'd0, out_vld}, 128'd1);
        end

        // R10: round trip
        for (int i = 0; i < 40; i++) begin
            bit k = 1'(i);
            x = rnd128();
            push(x, 1'b1, k);
            y = out_state;
            push(y, 1'b0, k);
            check("R10 round trip", out_state, x);
        end

        // R7: hold after a random burst
        held = out_state;
        repeat (3) @(negedge clk);
        check("R7 hold after burst", out_state, held);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule